// File: doc/BRIEF.md
# Partitioned Packed SIMD ALU

This block is a 64-bit integer datapath that splits both operands into independent lanes whose width is chosen on every operation: eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. A single adder built from byte slices serves all three widths. The carry between two byte slices is cut wherever a lane starts, so one lane's arithmetic never reaches its neighbour. Addition and subtraction come in three forms: wrapping, signed clamping and unsigned clamping. The block also provides lane-wise shifts, four bitwise operations and two compares. A compare writes a full mask into each lane, so later code can select data with a bitwise operation instead of a branch.

The issuing logic presents the two operands, an opcode, a lane-size code and a shift count, and raises `in_valid` for one cycle per operation. The result is registered. It appears one clock later together with `out_valid`, and it holds its value on cycles with no new operation. There is no internal sequencing: every cycle can carry an independent operation.

Top module: `simd_lane_alu`

## Requirements
- R1: `lane_sel` picks the lane layout: 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes, 2 gives two 32-bit lanes, and 3 behaves exactly like 2. Lane k of width w occupies bits [k*w+w-1 : k*w].
- R2: Wrapping add (opcode 0) and wrapping subtract (opcode 3) compute a+b and a-b modulo 2^w in each lane. No carry or borrow passes from one lane to the next.
- R3: Signed clamping add (opcode 1) and signed clamping subtract (opcode 4) treat each lane as two's complement. A result above 2^(w-1)-1 becomes 2^(w-1)-1, and a result below -2^(w-1) becomes -2^(w-1).
- R4: Unsigned clamping add (opcode 2) gives 2^w-1 when the true sum exceeds it. Unsigned clamping subtract (opcode 5) gives 0 when b is greater than a.
- R5: Shift-left logical (opcode 6), shift-right logical (opcode 7) and shift-right arithmetic (opcode 8) move each lane of `op_a` by the 6-bit `shamt`. A count of w or more gives 0 for the logical shifts and gives w copies of the lane's sign bit for the arithmetic shift.
- R6: Bitwise operations act on all 64 bits: AND (opcode 9), AND-NOT (opcode 10, computing (~op_a) & op_b), OR (opcode 11) and XOR (opcode 12).
- R7: Compare-equal (opcode 13) and signed compare-greater (opcode 14, true when a > b) write all ones into a lane when the condition holds and all zeros when it does not.
- R8: `out_valid` is high in exactly those cycles that follow a cycle with `in_valid` high. `out_data` takes the new result only after an accepted operation and holds its value otherwise. A synchronous active-high `rst` clears both outputs.
- R9: Opcode 15 is reserved and produces a result of all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accept an operation this cycle |
| opcode | input | 4 | Operation code (see R2 to R9) |
| lane_sel | input | 2 | Lane layout code (see R1) |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| shamt | input | 6 | Shift count, used by opcodes 6 to 8 |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_data | output | 64 | Registered lane-wise result |

## Verification
The bench sets up carry and borrow chains that cross every possible lane boundary at each width. A carry chain cut at the wrong place would leak a one into the neighbouring lane or drop a needed carry inside a 16-bit or 32-bit lane. It aims clamping operations at both limits and just below them. A design that took the overflow sign from the result, or tested overflow on the wrong byte of a wide lane, would clamp the wrong way or would clamp only part of the lane. It drives shift counts of w-1, w and 63, where a design that trusted the shifter to handle large counts would wrap the count or leave stale bits. It also checks signed compares on lanes whose top bits differ, where an unsigned compare would give the inverted mask.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADDS  = 4'd1,
        OP_ADDU  = 4'd2,
        OP_SUB   = 4'd3,
        OP_SUBS  = 4'd4,
        OP_SUBU  = 4'd5,
        OP_SLL   = 4'd6,
        OP_SRL   = 4'd7,
        OP_SRA   = 4'd8,
        OP_AND   = 4'd9,
        OP_ANDN  = 4'd10,
        OP_OR    = 4'd11,
        OP_XOR   = 4'd12,
        OP_CMPEQ = 4'd13,
        OP_CMPGT = 4'd14,
        OP_NONE  = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        SAT_WRAP     = 2'd0,
        SAT_SIGNED   = 2'd1,
        SAT_UNSIGNED = 2'd2
    } sat_mode_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RLOG  = 2'd1,
        SH_RARI  = 2'd2
    } shift_kind_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/lane_adder.sv
module lane_adder #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]        a,
    input  logic [DATA_W-1:0]        b,
    input  logic [1:0]               lane_sel,
    input  logic                     sub,
    output logic [DATA_W-1:0]        sum,
    output logic [DATA_W/8-1:0]      cout,
    output logic [DATA_W/8-1:0]      c_msb
);
    localparam int NBYTES = DATA_W / 8;

    logic [NBYTES-1:0] cin;
    logic [NBYTES-1:0] lane_start;

    for (genvar i = 0; i < NBYTES; i++) begin : g_slice
        localparam bit START16 = (i % 2) == 0;
        localparam bit START32 = (i % 4) == 0;

        logic [7:0] b_eff;
        logic [7:0] low7;
        logic [8:0] full;

        assign lane_start[i] = (lane_sel == 2'd0)
                             | ((lane_sel == 2'd1) & START16)
                             | (lane_sel[1] & START32);

        if (i == 0) begin : g_first
            assign cin[i] = sub;
        end else begin : g_rest
            assign cin[i] = lane_start[i] ? sub : cout[i-1];
        end

        assign b_eff    = b[i*8 +: 8] ^ {8{sub}};
        assign low7     = {1'b0, a[i*8 +: 7]} + {1'b0, b_eff[6:0]} + {7'b0, cin[i]};
        assign full     = {1'b0, a[i*8 +: 8]} + {1'b0, b_eff} + {8'b0, cin[i]};
        assign sum[i*8 +: 8] = full[7:0];
        assign cout[i]  = full[8];
        assign c_msb[i] = low7[7];
    end

endmodule

// File: rtl/lane_saturate.sv
module lane_saturate
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]    a,
    input  logic [DATA_W-1:0]    sum,
    input  logic [DATA_W/8-1:0]  cout,
    input  logic [DATA_W/8-1:0]  c_msb,
    input  logic [1:0]           lane_sel,
    input  logic                 sub,
    input  sat_mode_e            mode,
    output logic [DATA_W-1:0]    res
);
    localparam int NBYTES = DATA_W / 8;

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        localparam int TOP16 = i | 1;
        localparam int TOP32 = i | 3;

        logic top_cout, top_cmsb, top_sign, is_top;
        logic s_ovf, u_ovf;

        always_comb begin
            unique case (lane_sel)
                2'd0: begin
                    top_cout = cout[i];
                    top_cmsb = c_msb[i];
                    top_sign = a[i*8 + 7];
                    is_top   = 1'b1;
                end
                2'd1: begin
                    top_cout = cout[TOP16];
                    top_cmsb = c_msb[TOP16];
                    top_sign = a[TOP16*8 + 7];
                    is_top   = (i == TOP16);
                end
                default: begin
                    top_cout = cout[TOP32];
                    top_cmsb = c_msb[TOP32];
                    top_sign = a[TOP32*8 + 7];
                    is_top   = (i == TOP32);
                end
            endcase
        end

        assign s_ovf = top_cmsb ^ top_cout;
        assign u_ovf = sub ? ~top_cout : top_cout;

        always_comb begin
            res[i*8 +: 8] = sum[i*8 +: 8];
            if (mode == SAT_SIGNED && s_ovf) begin
                if (top_sign) res[i*8 +: 8] = is_top ? 8'h80 : 8'h00;
                else          res[i*8 +: 8] = is_top ? 8'h7F : 8'hFF;
            end else if (mode == SAT_UNSIGNED && u_ovf) begin
                res[i*8 +: 8] = sub ? 8'h00 : 8'hFF;
            end
        end
    end

endmodule

// File: rtl/lane_shifter.sv
module lane_shifter
    import simd_alu_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int SHAMT_W = 6
) (
    input  logic [DATA_W-1:0]  a,
    input  logic [1:0]         lane_sel,
    input  logic [SHAMT_W-1:0] shamt,
    input  shift_kind_e        kind,
    output logic [DATA_W-1:0]  res
);
    logic [DATA_W-1:0] part [3];

    for (genvar g = 0; g < 3; g++) begin : g_width
        localparam int W     = 8 << g;
        localparam int NLANE = DATA_W / W;
        for (genvar l = 0; l < NLANE; l++) begin : g_lane
            logic [W-1:0] x, y;
            assign x = a[l*W +: W];
            always_comb begin
                if (int'(shamt) >= W) begin
                    y = (kind == SH_RARI) ? {W{x[W-1]}} : '0;
                end else begin
                    unique case (kind)
                        SH_LEFT: y = x << shamt;
                        SH_RLOG: y = x >> shamt;
                        SH_RARI: y = $signed(x) >>> shamt;
                        default: y = '0;
                    endcase
                end
            end
            assign part[g][l*W +: W] = y;
        end
    end

    always_comb begin
        unique case (lane_sel)
            2'd0:    res = part[0];
            2'd1:    res = part[1];
            default: res = part[2];
        endcase
    end

endmodule

// File: rtl/lane_compare.sv
module lane_compare #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [1:0]        lane_sel,
    input  logic              want_gt,
    output logic [DATA_W-1:0] res
);
    logic [DATA_W-1:0] part [3];

    for (genvar g = 0; g < 3; g++) begin : g_width
        localparam int W     = 8 << g;
        localparam int NLANE = DATA_W / W;
        for (genvar l = 0; l < NLANE; l++) begin : g_lane
            logic [W-1:0] xa, xb;
            logic         hit;
            assign xa  = a[l*W +: W];
            assign xb  = b[l*W +: W];
            assign hit = want_gt ? ($signed(xa) > $signed(xb)) : (xa == xb);
            assign part[g][l*W +: W] = {W{hit}};
        end
    end

    always_comb begin
        unique case (lane_sel)
            2'd0:    res = part[0];
            2'd1:    res = part[1];
            default: res = part[2];
        endcase
    end

endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
    import simd_alu_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int SHAMT_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [3:0]         opcode,
    input  logic [1:0]         lane_sel,
    input  logic [DATA_W-1:0]  op_a,
    input  logic [DATA_W-1:0]  op_b,
    input  logic [SHAMT_W-1:0] shamt,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_data
);
    localparam int NBYTES = DATA_W / 8;

    alu_op_e           op;
    logic              is_sub;
    sat_mode_e         sat_mode;
    shift_kind_e       sh_kind;
    logic [DATA_W-1:0] add_sum, add_res, sh_res, cmp_res, next_data;
    logic [NBYTES-1:0] add_cout, add_cmsb;

    assign op = alu_op_e'(opcode);

    always_comb begin
        is_sub   = 1'b0;
        sat_mode = SAT_WRAP;
        sh_kind  = SH_LEFT;
        unique case (op)
            OP_ADDS: sat_mode = SAT_SIGNED;
            OP_ADDU: sat_mode = SAT_UNSIGNED;
            OP_SUB:  is_sub = 1'b1;
            OP_SUBS: begin is_sub = 1'b1; sat_mode = SAT_SIGNED;   end
            OP_SUBU: begin is_sub = 1'b1; sat_mode = SAT_UNSIGNED; end
            OP_SRL:  sh_kind = SH_RLOG;
            OP_SRA:  sh_kind = SH_RARI;
            default: ;
        endcase
    end

    lane_adder #(.DATA_W(DATA_W)) u_adder (
        .a(op_a), .b(op_b), .lane_sel(lane_sel), .sub(is_sub),
        .sum(add_sum), .cout(add_cout), .c_msb(add_cmsb)
    );

    lane_saturate #(.DATA_W(DATA_W)) u_sat (
        .a(op_a), .sum(add_sum), .cout(add_cout), .c_msb(add_cmsb),
        .lane_sel(lane_sel), .sub(is_sub), .mode(sat_mode), .res(add_res)
    );

    lane_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
        .a(op_a), .lane_sel(lane_sel), .shamt(shamt), .kind(sh_kind), .res(sh_res)
    );

    lane_compare #(.DATA_W(DATA_W)) u_cmp (
        .a(op_a), .b(op_b), .lane_sel(lane_sel), .want_gt(op == OP_CMPGT), .res(cmp_res)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_ADDS, OP_ADDU,
            OP_SUB, OP_SUBS, OP_SUBU:  next_data = add_res;
            OP_SLL, OP_SRL, OP_SRA:    next_data = sh_res;
            OP_AND:                    next_data = op_a & op_b;
            OP_ANDN:                   next_data = ~op_a & op_b;
            OP_OR:                     next_data = op_a | op_b;
            OP_XOR:                    next_data = op_a ^ op_b;
            OP_CMPEQ, OP_CMPGT:        next_data = cmp_res;
            OP_NONE:                   next_data = '0;
            default:                   next_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= next_data;
        end
    end

    function automatic bit mask_ok(input logic [DATA_W-1:0] d, input logic [1:0] ls);
        int lb;
        lb = (ls == 2'd0) ? 1 : (ls == 2'd1) ? 2 : 4;
        for (int i = 0; i < NBYTES; i++) begin
            if (d[i*8 +: 8] != 8'h00 && d[i*8 +: 8] != 8'hFF) return 1'b0;
            if (d[i*8 +: 8] != d[(i | (lb - 1))*8 +: 8]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic bit bytes_ge(input logic [DATA_W-1:0] d, input logic [DATA_W-1:0] a);
        for (int i = 0; i < NBYTES; i++)
            if (d[i*8 +: 8] < a[i*8 +: 8]) return 1'b0;
        return 1'b1;
    endfunction

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R8
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R8
    AST_IDLE_HOLDS_DATA: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(out_data)); // R8
    AST_ANDN_RESULT: assert property (@(posedge clk) disable iff (rst) (in_valid && opcode == 4'd10) |=> out_data == (~$past(op_a) & $past(op_b))); // R6
    AST_CMP_MASK: assert property (@(posedge clk) disable iff (rst) (in_valid && (opcode == 4'd13 || opcode == 4'd14)) |=> mask_ok(out_data, $past(lane_sel))); // R7
    AST_USAT_NO_WRAP: assert property (@(posedge clk) disable iff (rst) (in_valid && opcode == 4'd2 && lane_sel == 2'd0) |=> bytes_ge(out_data, $past(op_a))); // R4
    AST_NONE_ZERO: assert property (@(posedge clk) disable iff (rst) (in_valid && opcode == 4'd15) |=> out_data == '0); // R9

endmodule

// File: tb/simd_lane_alu_bench.sv
module simd_lane_alu_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  opcode = '0;
    logic [1:0]  lane_sel = '0;
    logic [63:0] op_a = '0, op_b = '0;
    logic [5:0]  shamt = '0;
    logic        out_valid;
    logic [63:0] out_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    simd_lane_alu u_simd_lane_alu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .lane_sel(lane_sel), .op_a(op_a), .op_b(op_b), .shamt(shamt),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [63:0] ref_alu(input logic [3:0] op, input logic [1:0] ls,
                                            input logic [63:0] a, input logic [63:0] b,
                                            input logic [5:0] sh);
        int w, n, s;
        logic [63:0] mask, r, rv;
        longint unsigned ua, ub, sbit;
        longint sa, sb, res, hi, lo;
        w = (ls == 2'd0) ? 8 : (ls == 2'd1) ? 16 : 32;
        n = 64 / w;
        mask = (64'd1 << w) - 64'd1;
        sbit = 64'd1 << (w - 1);
        hi = longint'(sbit) - 1;
        lo = -longint'(sbit);
        s = int'(sh);
        r = '0;
        for (int l = 0; l < n; l++) begin
            ua = (a >> (l * w)) & mask;
            ub = (b >> (l * w)) & mask;
            sa = longint'(ua ^ sbit) - longint'(sbit);
            sb = longint'(ub ^ sbit) - longint'(sbit);
            case (op)
                4'd0:  res = longint'(ua + ub);
                4'd1:  begin res = sa + sb; if (res > hi) res = hi; if (res < lo) res = lo; end
                4'd2:  begin res = longint'(ua + ub); if (res > longint'(mask)) res = longint'(mask); end
                4'd3:  res = longint'(ua - ub);
                4'd4:  begin res = sa - sb; if (res > hi) res = hi; if (res < lo) res = lo; end
                4'd5:  res = (ua < ub) ? 0 : longint'(ua - ub);
                4'd6:  res = (s >= w) ? 0 : longint'(ua << s);
                4'd7:  res = (s >= w) ? 0 : longint'(ua >> s);
                4'd8:  res = sa >>> ((s >= w) ? (w - 1) : s);
                4'd9:  res = longint'(ua & ub);
                4'd10: res = longint'(~ua & ub);
                4'd11: res = longint'(ua | ub);
                4'd12: res = longint'(ua ^ ub);
                4'd13: res = (ua == ub) ? longint'(mask) : 0;
                4'd14: res = (sa > sb) ? longint'(mask) : 0;
                default: res = 0;
            endcase
            rv = res;
            r = r | ((rv & mask) << (l * w));
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd3:   return "R2";
            4'd1, 4'd4:   return "R3";
            4'd2, 4'd5:   return "R4";
            4'd6, 4'd7, 4'd8: return "R5";
            4'd13, 4'd14: return "R7";
            4'd15:        return "R9";
            default:      return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] op, input logic [1:0] ls, input logic [63:0] a,
                       input logic [63:0] b, input logic [5:0] sh, input string tag);
        logic [63:0] exp;
        @(negedge clk);
        in_valid = 1'b1; opcode = op; lane_sel = ls; op_a = a; op_b = b; shamt = sh;
        exp = ref_alu(op, ls, a, b, sh);
        @(posedge clk); #1;
        check({tag, " valid"}, {63'd0, out_valid}, 64'd1);
        check(tag, out_data, exp);
    endtask

    function automatic logic [63:0] pick();
        case ($urandom % 6)
            0: return 64'h0;
            1: return '1;
            2: return 64'h7F7F_7FFF_7FFF_FFFF;
            3: return 64'h8080_8000_8000_0000;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        logic [63:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check("R8 reset valid", {63'd0, out_valid}, 64'd0);
        check("R8 reset data", out_data, 64'd0);

        // R1 / R2: carries that would cross lane boundaries at each width
        for (int ls = 0; ls < 4; ls++) begin
            run(4'd0, 2'(ls), 64'h00FF_00FF_FFFF_FFFF, 64'h0001_0001_0000_0001, 6'd0, "R1 R2 add carry cut");
            run(4'd3, 2'(ls), 64'h0000_0100_0000_0000, 64'h0000_0001_0000_0001, 6'd0, "R1 R2 sub borrow cut");
        end
        // R3 signed clamp limits
        run(4'd1, 2'd0, 64'h7F7E_8081_0000_7F80, 64'h0101_FFFF_0000_0180, 6'd0, "R3 add8");
        run(4'd1, 2'd2, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_FFFF_FFFF, 6'd0, "R3 add32");
        run(4'd4, 2'd1, 64'h8000_7FFF_8001_0005, 64'h0001_FFFF_0001_0007, 6'd0, "R3 sub16");
        // R4 unsigned clamp limits
        run(4'd2, 2'd1, 64'hFFFF_FFFE_0001_8000, 64'h0001_0001_FFFE_8000, 6'd0, "R4 add16");
        run(4'd5, 2'd0, 64'h0001_0203_FF00_1010, 64'h0201_0304_00FF_1011, 6'd0, "R4 sub8");
        // R5 shift counts at w-1, w and 63
        run(4'd6, 2'd0, 64'h8181_8181_8181_8181, '0, 6'd7, "R5 sll w-1");
        run(4'd7, 2'd1, 64'h8001_8001_8001_8001, '0, 6'd16, "R5 srl w");
        run(4'd8, 2'd2, 64'h8000_0001_7FFF_FFFF, '0, 6'd63, "R5 sra 63");
        run(4'd8, 2'd0, 64'h80FF_7F01_C040_0180, '0, 6'd3, "R5 sra 3");
        // R6 AND-NOT order
        run(4'd10, 2'd0, 64'hF0F0_0000_FFFF_1234, 64'hFF00_FFFF_0F0F_FFFF, 6'd0, "R6 andn");
        // R7 signed compare
        run(4'd14, 2'd0, 64'h7F80_0001_FF00_1010, 64'h807F_0100_00FF_1010, 6'd0, "R7 gt8");
        run(4'd13, 2'd1, 64'h1234_0000_FFFF_0001, 64'h1234_0001_FFFF_0100, 6'd0, "R7 eq16");
        // R9 reserved opcode
        run(4'd15, 2'd0, '1, '1, 6'd5, "R9 reserved");

        // R8 idle cycle: no valid, data held
        held = out_data;
        @(negedge clk);
        in_valid = 1'b0; opcode = 4'd12; op_a = '1; op_b = 64'h5;
        @(posedge clk); #1;
        check("R8 idle valid", {63'd0, out_valid}, 64'd0);
        check("R8 idle hold", out_data, held);

        for (int k = 0; k < 3000; k++) begin
            logic [3:0] op;
            op = 4'($urandom % 16);
            run(op, 2'($urandom % 4), pick(), pick(), 6'($urandom % 64), tag_of(op));
        end

        @(negedge clk); in_valid = 1'b0;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule